// File: doc/BRIEF.md
# Frame Alignment Offset Measurement Unit

This block measures how far an external frame-evaluation signal lags the local frame pulse. The result has half-clock resolution. Software uses the figure to choose a per-stream input offset. The measurement runs as a handshake. Software holds a start bit low for at least one frame, then raises it. The unit waits for the next reference edge of the frame pulse and counts master-clock cycles from it. It records the first evaluated edge of the evaluation input, together with the clock phase in which that edge arrived. At the second reference edge after the start, it raises a complete flag.

The frame format selects which edges are compared. In ST-BUS format both the frame pulse and the evaluation input are compared on their falling edges. In GCI format both are compared on their rising edges. Lowering the start bit clears the flag and the result, ready for another run. The result also appears in a 16-bit status word laid out for a register read.

Top module: `frame_align_meas`

## Requirements
- R1: While reset is held and after it is released, `measDone`, `measResult` and `statusWord` are all zero.
- R2: A start is accepted only on a rising edge of `startBit`. The first reference edge after that start opens the measurement frame. `measDone` rises in the clock that detects the following reference edge, and not earlier.
- R3: With `gciMode` = 0 (ST-BUS), the reference is a falling edge of `framePulse` and the evaluated edge is a falling edge of `evalIn`. Rising edges of either signal have no effect.
- R4: With `gciMode` = 1 (GCI), the reference is a rising edge of `framePulse` and the evaluated edge is a rising edge of `evalIn`. Falling edges have no effect.
- R5: `measResult[10:0]` holds the number of rising clock edges from the one that first sees the reference edge to the one that first sees the evaluated edge. This count is never zero once `measDone` is 1.
- R6: `measResult[11]` is 1 when the evaluated edge occurred while the clock was high, between a rising edge and the next falling edge. It is 0 when the edge occurred while the clock was low.
- R7: Only the first evaluated edge inside the measurement frame is recorded. Later evaluated edges leave the result unchanged.
- R8: If no evaluated edge arrives in the measurement frame, `measDone` still rises, `measResult[10:0]` reads all ones (2047) and `measResult[11]` reads 0.
- R9: A 1-to-0 change of `startBit` clears `measDone` and `measResult` to zero on the next clock edge, whatever the state.
- R10: A rising edge of `startBit` is ignored unless at least one reference edge occurred while `startBit` was low before it.
- R11: `statusWord[11:0]` equals `measResult`, `statusWord[12]` equals `measDone`, and `statusWord[15:13]` read 0.
- R12: While `measDone` is 1 and `startBit` stays high, the result holds its value through any further frame or evaluation edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; rising edge is the count edge |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | Local frame pulse (reference) |
| evalIn | input | 1 | Frame evaluation signal being measured |
| startBit | input | 1 | Measurement start control from software |
| gciMode | input | 1 | Frame format: 0 = ST-BUS (falling edges), 1 = GCI (rising edges) |
| measDone | output | 1 | Measurement complete flag |
| measResult | output | 12 | Phase bit 11, offset count bits 10..0 |
| statusWord | output | 16 | Register view: result, complete flag at bit 12, zeros above |

## Verification
The assertions assume that `framePulse` and `evalIn` change only away from both clock edges. They also assume that the frame format changes only while `startBit` is low, with both input levels flipped at the same moment. Finally, they assume that no evaluated edge lands in the same cycle as a reference edge, and that `startBit` does not toggle faster than the clock. The stimulus follows these rules. It moves every input a quarter period after a clock edge, or three quarters after one to place an edge in the low phase. It switches format together with the idle levels of both signals, and it keeps each evaluated edge at least one cycle after its reference edge and well before the frame ends. The vectors cover both formats, both clock phases, repeated edges, missing edges and edges of the wrong polarity.

// File: rtl/fa_pkg.sv
`timescale 1ns/100ps
package fa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAITREF = 2'd1,
    ST_MEASURE = 2'd2,
    ST_DONE    = 2'd3
  } faState_t;

  typedef struct packed {
    logic clrCnt;   // restart the cycle counter at the opening reference edge
    logic capEn;    // record count and phase of the first evaluated edge
    logic setDone;  // raise the complete flag
    logic loadSat;  // no edge seen: load the saturated count
    logic clrAll;   // start dropped: clear flag and result
  } faStrobes_t;

endpackage

// File: rtl/fa_ctrl.sv
`timescale 1ns/100ps
module fa_ctrl
  import fa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       refEdge,
  input  logic       evalEdge,
  output faStrobes_t strobes
);

  faState_t state;
  logic     startPrev;
  logic     armed;
  logic     captured;
  logic     startRise;
  logic     startFall;

  assign startRise = startBit & ~startPrev;
  assign startFall = ~startBit & startPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startPrev <= 1'b0;
      armed     <= 1'b0;
      captured  <= 1'b0;
    end else begin
      startPrev <= startBit;
      // a reference edge seen while start is low qualifies the next start
      if (startBit)     armed <= 1'b0;
      else if (refEdge) armed <= 1'b1;

      if (startFall) begin
        state    <= ST_IDLE;
        captured <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (startRise && armed) state <= ST_WAITREF;
          end
          ST_WAITREF: begin
            if (refEdge) begin
              state    <= ST_MEASURE;
              captured <= 1'b0;
            end
          end
          ST_MEASURE: begin
            if (refEdge)                    state    <= ST_DONE;
            else if (evalEdge && !captured) captured <= 1'b1;
          end
          ST_DONE: begin
            state <= ST_DONE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobes = '0;
    if (startFall) begin
      strobes.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_WAITREF: strobes.clrCnt = refEdge;
        ST_MEASURE: begin
          if (refEdge) begin
            strobes.setDone = 1'b1;
            strobes.loadSat = ~captured;
          end else if (evalEdge && !captured) begin
            strobes.capEn = 1'b1;
          end
        end
        default: strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/fa_datapath.sv
`timescale 1ns/100ps
module fa_datapath
  import fa_pkg::*;
#(
  parameter int CNT_W = 11,
  localparam int RES_W = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             evalIn,
  input  logic             gciMode,
  input  faStrobes_t       strobes,
  output logic             refEdge,
  output logic             evalEdge,
  output logic             measDone,
  output logic [RES_W-1:0] measResult
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // XOR with the format flag turns the compared edge into a falling edge
  logic fpNorm;
  logic evNorm;
  logic fpPrev;
  logic evPrev;
  logic evMid;
  logic edgeHigh;
  logic edgeLow;

  logic [CNT_W-1:0] cycleCnt;
  logic [CNT_W-1:0] capCnt;
  logic [CNT_W-1:0] resCnt;
  logic             resPhase;

  assign fpNorm = framePulse ^ gciMode;
  assign evNorm = evalIn ^ gciMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpPrev <= 1'b1;
      evPrev <= 1'b1;
    end else begin
      fpPrev <= fpNorm;
      evPrev <= evNorm;
    end
  end

  // mid-cycle sample splits each period into its high and low halves
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) evMid <= 1'b1;
    else       evMid <= evNorm;
  end

  assign refEdge  = fpPrev & ~fpNorm;
  assign edgeHigh = evPrev & ~evMid;
  assign edgeLow  = evMid & ~evNorm;
  assign evalEdge = edgeHigh | edgeLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycleCnt <= '0;
    end else if (strobes.clrCnt) begin
      cycleCnt <= '0;
    end else if (cycleCnt != CNT_MAX) begin
      cycleCnt <= cycleCnt + 1'b1;
    end
  end

  assign capCnt = (cycleCnt == CNT_MAX) ? CNT_MAX : cycleCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resCnt   <= '0;
      resPhase <= 1'b0;
      measDone <= 1'b0;
    end else if (strobes.clrAll) begin
      resCnt   <= '0;
      resPhase <= 1'b0;
      measDone <= 1'b0;
    end else begin
      if (strobes.capEn) begin
        resCnt   <= capCnt;
        resPhase <= edgeHigh;
      end else if (strobes.loadSat) begin
        resCnt   <= CNT_MAX;
        resPhase <= 1'b0;
      end
      if (strobes.setDone) measDone <= 1'b1;
    end
  end

  assign measResult = {resPhase, resCnt};

endmodule

// File: rtl/frame_align_meas.sv
`timescale 1ns/100ps
module frame_align_meas
  import fa_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int STATUS_W = 16,
  localparam int RES_W   = CNT_W + 1,
  localparam int PAD_W   = STATUS_W - RES_W - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                framePulse,
  input  logic                evalIn,
  input  logic                startBit,
  input  logic                gciMode,
  output logic                measDone,
  output logic [RES_W-1:0]    measResult,
  output logic [STATUS_W-1:0] statusWord
);

  faStrobes_t strobes;
  logic       refEdge;
  logic       evalEdge;

  fa_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startBit (startBit),
    .refEdge  (refEdge),
    .evalEdge (evalEdge),
    .strobes  (strobes)
  );

  fa_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .evalIn     (evalIn),
    .gciMode    (gciMode),
    .strobes    (strobes),
    .refEdge    (refEdge),
    .evalEdge   (evalEdge),
    .measDone   (measDone),
    .measResult (measResult)
  );

  assign statusWord = {{PAD_W{1'b0}}, measDone, measResult};

endmodule

// File: rtl/fa_checker.sv
`timescale 1ns/100ps
module fa_checker #(
  parameter int CNT_W = 11,
  localparam int RES_W = CNT_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             startBit,
  input logic             refEdge,
  input logic             measDone,
  input logic [RES_W-1:0] measResult
);

  // R2: completion follows a reference edge detected one clock earlier
  assert_done_after_ref_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measDone) |-> $past(refEdge));

  // R2: the flag is only held while a start is in force
  assert_done_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    measDone |-> (startBit || $fell(startBit)));

  // R5: a completed count is never zero
  assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    measDone |-> (measResult[CNT_W-1:0] != '0));

  // R7: a nonzero result is only ever written over a cleared one
  assert_single_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((measResult != $past(measResult)) && (measResult != '0)) |-> ($past(measResult) == '0));

  // R9: dropping the start clears everything on the next edge
  assert_clear_on_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |=> (!measDone && (measResult == '0)));

  // R12: result is frozen while complete and start held
  assert_hold_when_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    (measDone && startBit) |=> $stable(measResult));

endmodule

bind frame_align_meas fa_checker #(.CNT_W(CNT_W)) u_fa_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startBit   (startBit),
  .refEdge    (refEdge),
  .measDone   (measDone),
  .measResult (measResult)
);

// File: tb/tb_frame_align_meas.sv
`timescale 1ns/100ps
module tb_frame_align_meas;

  localparam int FRAME   = 64;
  localparam int NVEC    = 12;
  localparam int WD_CYC  = 100000;
  localparam logic [10:0] SAT = 11'h7FF;

  // fields: [11] gci, [10:3] offset, [2] high-phase, [1:0] mode
  // mode 0 single edge, 1 two edges, 2 no edge, 3 wrong-polarity edge only
  localparam logic [11:0] VECS [NVEC] = '{
    {1'b0, 8'd5,  1'b1, 2'd0},
    {1'b0, 8'd5,  1'b0, 2'd0},
    {1'b0, 8'd1,  1'b0, 2'd0},
    {1'b1, 8'd12, 1'b1, 2'd0},
    {1'b1, 8'd40, 1'b0, 2'd0},
    {1'b0, 8'd55, 1'b0, 2'd0},
    {1'b0, 8'd20, 1'b1, 2'd1},
    {1'b1, 8'd9,  1'b0, 2'd1},
    {1'b0, 8'd0,  1'b0, 2'd2},
    {1'b1, 8'd0,  1'b0, 2'd2},
    {1'b0, 8'd15, 1'b1, 2'd3},
    {1'b1, 8'd15, 1'b1, 2'd3}
  };

  logic        clk;
  logic        rstN;
  logic        framePulse;
  logic        evalIn;
  logic        startBit;
  logic        gciMode;
  logic        measDone;
  logic [11:0] measResult;
  logic [15:0] statusWord;

  int checks;
  int errors;

  frame_align_meas dut (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .evalIn     (evalIn),
    .startBit   (startBit),
    .gciMode    (gciMode),
    .measDone   (measDone),
    .measResult (measResult),
    .statusWord (statusWord)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // called a quarter period after a rising edge; returns at the same point
  task automatic refPulse(input bit g);
    framePulse = g;           // active level: low for ST-BUS, high for GCI
    @(posedge clk); #2.5;
    framePulse = ~g;
  endtask

  task automatic runCycles(input int n, input bit g, input int off, input bit half, input int mode);
    for (int c = 1; c <= n; c++) begin
      if (mode == 0 || mode == 1) begin
        if (c == off && half)  evalIn = g;
        if (c == off + 3)      evalIn = ~g;
      end
      if (mode == 1) begin
        if (c == off + 5)      evalIn = g;
        if (c == off + 8)      evalIn = ~g;
      end
      if (mode == 3 && c == off) evalIn = ~g;
      #5;
      if ((mode == 0 || mode == 1) && c == off && !half) evalIn = g;
      @(posedge clk); #2.5;
    end
  endtask

  task automatic measure(input bit g, input int off, input bit half, input int mode,
                         input logic [11:0] expRes, input string tag);
    gciMode    = g;
    framePulse = ~g;
    evalIn     = (mode == 3) ? g : ~g;
    refPulse(g);
    runCycles(FRAME - 1, g, 0, 1'b0, 2);
    startBit = 1'b1;
    runCycles(2, g, 0, 1'b0, 2);
    refPulse(g);
    runCycles(FRAME - 1, g, off, half, mode);
    chk({"R2 early ", tag}, measDone, 0);
    refPulse(g);
    chk({"R2 done ", tag}, measDone, 1);
    chk(tag, measResult, expRes);
    chk({"R11 ", tag}, statusWord, {3'b000, 1'b1, expRes});
    startBit = 1'b0;
    runCycles(1, g, 0, 1'b0, 2);
    chk({"R9 done ", tag}, measDone, 0);
    chk({"R9 result ", tag}, measResult, 0);
  endtask

  initial begin
    #(WD_CYC * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rstN = 1'b0;
    framePulse = 1'b1;
    evalIn = 1'b1;
    startBit = 1'b0;
    gciMode = 1'b0;
    repeat (3) @(posedge clk);
    #2.5;
    chk("R1 done in reset", measDone, 0);
    chk("R1 status in reset", statusWord, 0);
    rstN = 1'b1;
    @(posedge clk); #2.5;
    chk("R1 result after reset", measResult, 0);
    chk("R1 status after reset", statusWord, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic        g;
      int          off;
      logic        half;
      int          mode;
      logic [11:0] expRes;
      string       tag;
      g    = VECS[i][11];
      off  = int'(VECS[i][10:3]);
      half = VECS[i][2];
      mode = int'(VECS[i][1:0]);
      if (mode == 2 || mode == 3) expRes = {1'b0, SAT};
      else                        expRes = {half, 11'(off)};
      case (mode)
        1:       tag = "R7 first edge";
        2:       tag = "R8 no edge";
        3:       tag = g ? "R4 wrong polarity" : "R3 wrong polarity";
        default: tag = g ? "R4 R5 R6 gci" : "R3 R5 R6 st";
      endcase
      measure(g, off, half, mode, expRes, $sformatf("%s vec %0d", tag, i));
    end

    // R10: a start without a prior reference edge while low is ignored
    gciMode = 1'b0; framePulse = 1'b1; evalIn = 1'b1;
    startBit = 1'b1;
    runCycles(2, 1'b0, 0, 1'b0, 2);
    refPulse(1'b0);
    runCycles(FRAME - 1, 1'b0, 5, 1'b1, 0);
    refPulse(1'b0);
    runCycles(FRAME - 1, 1'b0, 0, 1'b0, 2);
    refPulse(1'b0);
    runCycles(3, 1'b0, 0, 1'b0, 2);
    chk("R10 unarmed start done", measDone, 0);
    chk("R10 unarmed start result", measResult, 0);
    startBit = 1'b0;
    runCycles(1, 1'b0, 0, 1'b0, 2);

    // R12: result frozen after completion while start stays high
    refPulse(1'b0);
    runCycles(FRAME - 1, 1'b0, 0, 1'b0, 2);
    startBit = 1'b1;
    runCycles(2, 1'b0, 0, 1'b0, 2);
    refPulse(1'b0);
    runCycles(FRAME - 1, 1'b0, 7, 1'b1, 0);
    refPulse(1'b0);
    chk("R12 first result", measResult, {1'b1, 11'd7});
    runCycles(FRAME - 1, 1'b0, 3, 1'b0, 0);
    refPulse(1'b0);
    runCycles(10, 1'b0, 2, 1'b0, 0);
    chk("R12 done held", measDone, 1);
    chk("R12 result held", measResult, {1'b1, 11'd7});
    startBit = 1'b0;
    runCycles(1, 1'b0, 0, 1'b0, 2);
    chk("R9 clear after hold", statusWord, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule